// File: doc/BRIEF.md
# UART Modem Handshake Control and Status Unit

This block holds the modem control register and the modem status register of a 16550-class serial port. The control register drives four active-low handshake outputs: terminal-ready, request-to-send and two general-purpose user outputs. One control bit selects a loopback mode. In that mode the outputs are held inactive and the control bits are routed back into the status inputs.

The four active-low modem inputs (clear-to-send, data-set-ready, ring, carrier-detect) pass through a synchronizer. The status register reports their complemented levels. It also reports sticky change flags that stay set until the host reads the status register. When any flag is set and the host has enabled modem-status interrupts, an interrupt request is raised. A host interface outside the block supplies one-cycle write and read strobes; this block does no address decoding.

Top module: `uart_modem_ctl`

## Requirements
- R1: Status bits 7:4 read as the complement of carrier-detect, ring, data-set-ready and clear-to-send, in that order from bit 7 down. A pin change appears in the status two clock edges after it is applied, because of the two-stage synchronizer.
- R2: Status bit 0 (clear-to-send), bit 1 (data-set-ready) and bit 3 (carrier-detect) are set one edge after the synchronized level of that input changes in either direction.
- R3: Status bit 2 is set only when the synchronized ring input goes from low back to high. A falling ring input leaves it unchanged.
- R4: Change flags in bits 3:0 stay set until a status read. The edge that completes a read clears them. A change detected on that same edge is kept.
- R5: The interrupt output is high exactly when the interrupt enable input is high and at least one change flag is set. A status read clears it, unless a new change is detected on the same edge.
- R6: Outside loopback, control bit 0 drives terminal-ready low, bit 1 drives request-to-send low, bit 2 drives user output 1 low and bit 3 drives user output 2 low. Each output is high when its bit is 0.
- R7: While control bit 4 (loopback) is 1, all four handshake outputs are high, whatever control bits 3:0 hold.
- R8: In loopback, the internal inputs come from the control bits and the pins are ignored. Request-to-send (bit 1) feeds clear-to-send, terminal-ready (bit 0) feeds data-set-ready, user output 1 (bit 2) feeds ring, and user output 2 (bit 3) feeds carrier-detect. A set control bit reads as a 1 in the matching status level bit.
- R9: Reset clears the control register, all change flags and the interrupt, and drives all four handshake outputs high.
- R10: A control write stores data bits 4:0. The control readback shows those five bits, and bits 7:5 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous master reset, active high |
| wr_ctl | input | 1 | One-cycle write strobe for the control register |
| wr_data | input | 8 | Write data |
| rd_stat | input | 1 | One-cycle read strobe for the status register; clears change flags |
| msi_en | input | 1 | Modem-status interrupt enable |
| clr_send_n | input | 1 | Clear-to-send, active low, asynchronous |
| set_ready_n | input | 1 | Data-set-ready, active low, asynchronous |
| ring_n | input | 1 | Ring indicator, active low, asynchronous |
| carrier_n | input | 1 | Carrier-detect, active low, asynchronous |
| term_ready_n | output | 1 | Terminal-ready, active low |
| req_send_n | output | 1 | Request-to-send, active low |
| user1_n | output | 1 | User output 1, active low |
| user2_n | output | 1 | User output 2, active low |
| ctl_rdata | output | 8 | Control register readback |
| stat_rdata | output | 8 | Status register value |
| irq | output | 1 | Modem-status interrupt request |

## Verification
The assertions check on every cycle that a detected change sets its flag and that flags persist without a read. They also check that a read with no new change drops the interrupt, and that a detected change raises it when enabled. Two further properties cover the handshake outputs: they follow the control bits or, in loopback, are all held high. A last property ties the loopback status levels to the control readback. Only the bench scenarios can show the two-edge synchronizer latency from pin to status and the reset values. The same holds for the ring edge polarity and the corner case of a change detected on the very edge of a read, all of which the cycle-by-cycle reference model compares.

// File: rtl/uart_mdm_pkg.sv
`timescale 1ns/1ps
package uart_mdm_pkg;
  localparam int NLINES = 4;   // internal line order: 0 clr_send, 1 set_ready, 2 ring, 3 carrier
  localparam int CTL_W  = 5;   // control bits 4:0
  localparam int LOOP_BIT = 4;
  localparam int RING_IDX = 2;
  localparam int STAT_W = 2 * NLINES;

  // loopback routing: control bit -> active-low internal line
  function automatic logic [NLINES-1:0] loop_map(input logic [CTL_W-1:0] c);
    logic [NLINES-1:0] l;
    l[0] = ~c[1];
    l[1] = ~c[0];
    l[2] = ~c[2];
    l[3] = ~c[3];
    return l;
  endfunction

  // change events: any toggle, except ring which reports only its low-to-high return
  function automatic logic [NLINES-1:0] line_events(input logic [NLINES-1:0] prev,
                                                     input logic [NLINES-1:0] cur);
    logic [NLINES-1:0] e;
    e = prev ^ cur;
    e[RING_IDX] = ~prev[RING_IDX] & cur[RING_IDX];
    return e;
  endfunction

  function automatic logic [STAT_W-1:0] pack_status(input logic [NLINES-1:0] line,
                                                     input logic [NLINES-1:0] flags);
    return {~line, flags};
  endfunction
endpackage

// File: rtl/mdm_sync.sv
`timescale 1ns/1ps
module mdm_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= '1;
        else if (s == 0) stg[s] <= din;
        else stg[s] <= stg[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/mdm_ctrl_reg.sv
`timescale 1ns/1ps
module mdm_ctrl_reg
  import uart_mdm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [CTL_W-1:0]  wdata,
  output logic [CTL_W-1:0]  ctl,
  output logic              loop_on,
  output logic [NLINES-1:0] outs_n
);
  always_ff @(posedge clk) begin
    if (rst) ctl <= '0;
    else if (wr) ctl <= wdata;
  end

  assign loop_on = ctl[LOOP_BIT];

  generate
    for (genvar i = 0; i < NLINES; i++) begin : g_out
      assign outs_n[i] = ~ctl[i] | loop_on;
    end
  endgenerate
endmodule

// File: rtl/mdm_status.sv
`timescale 1ns/1ps
module mdm_status
  import uart_mdm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [NLINES-1:0] line,
  input  logic              rd,
  input  logic              int_en,
  output logic [STAT_W-1:0] status,
  output logic              irq,
  output logic [NLINES-1:0] evt,
  output logic [NLINES-1:0] flags
);
  logic [NLINES-1:0] prev;

  assign evt = line_events(prev, line);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev  <= '1;
      flags <= '0;
    end else begin
      prev  <= line;
      flags <= (rd ? '0 : flags) | evt;
    end
  end

  assign status = pack_status(line, flags);
  assign irq    = int_en & (|flags);
endmodule

// File: rtl/uart_modem_ctl.sv
`timescale 1ns/1ps
module uart_modem_ctl
  import uart_mdm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_ctl,
  input  logic [7:0] wr_data,
  input  logic       rd_stat,
  input  logic       msi_en,
  input  logic       clr_send_n,
  input  logic       set_ready_n,
  input  logic       ring_n,
  input  logic       carrier_n,
  output logic       term_ready_n,
  output logic       req_send_n,
  output logic       user1_n,
  output logic       user2_n,
  output logic [7:0] ctl_rdata,
  output logic [7:0] stat_rdata,
  output logic       irq
);
  logic [CTL_W-1:0]  ctl;
  logic              loop_on;
  logic [NLINES-1:0] outs_n;
  logic [NLINES-1:0] pins_sync;
  logic [NLINES-1:0] line_int;
  logic [NLINES-1:0] evt;
  logic [NLINES-1:0] flags;

  mdm_ctrl_reg u_ctrl (
    .clk(clk), .rst(rst), .wr(wr_ctl), .wdata(wr_data[CTL_W-1:0]),
    .ctl(ctl), .loop_on(loop_on), .outs_n(outs_n)
  );

  mdm_sync #(.W(NLINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .din({carrier_n, ring_n, set_ready_n, clr_send_n}),
    .dout(pins_sync)
  );

  assign line_int = loop_on ? loop_map(ctl) : pins_sync;

  mdm_status u_stat (
    .clk(clk), .rst(rst), .line(line_int), .rd(rd_stat), .int_en(msi_en),
    .status(stat_rdata), .irq(irq), .evt(evt), .flags(flags)
  );

  assign term_ready_n = outs_n[0];
  assign req_send_n   = outs_n[1];
  assign user1_n      = outs_n[2];
  assign user2_n      = outs_n[3];
  assign ctl_rdata    = {{(8-CTL_W){1'b0}}, ctl};
endmodule

// File: rtl/uart_modem_ctl_chk.sv
`timescale 1ns/1ps
module uart_modem_ctl_chk (
  input logic       clk,
  input logic       rst,
  input logic       rd_stat,
  input logic       msi_en,
  input logic       irq,
  input logic       loop_on,
  input logic [3:0] evt,
  input logic [3:0] flags,
  input logic [3:0] outs_n,
  input logic [7:0] stat_rdata,
  input logic [7:0] ctl_rdata
);
  p_flag_set_r2: assert property (@(posedge clk) disable iff (rst)
    ((evt & 4'hB) != 4'h0) |=> ((flags & $past(evt & 4'hB)) == $past(evt & 4'hB)));

  p_ring_flag_r3: assert property (@(posedge clk) disable iff (rst)
    evt[2] |=> flags[2]);

  p_flags_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    !rd_stat |=> ((flags & $past(flags)) == $past(flags)));

  p_irq_raise_r5: assert property (@(posedge clk) disable iff (rst)
    (evt != 4'h0) |=> (!msi_en || irq));

  p_irq_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_stat && evt == 4'h0) |=> !irq);

  p_outs_follow_r6: assert property (@(posedge clk) disable iff (rst)
    !loop_on |-> (outs_n == ~ctl_rdata[3:0]));

  p_loop_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    loop_on |-> (outs_n == 4'hF));

  p_loop_route_r8: assert property (@(posedge clk) disable iff (rst)
    loop_on |-> (stat_rdata[4] == ctl_rdata[1] && stat_rdata[5] == ctl_rdata[0] &&
                 stat_rdata[6] == ctl_rdata[2] && stat_rdata[7] == ctl_rdata[3]));
endmodule

bind uart_modem_ctl uart_modem_ctl_chk u_chk (
  .clk(clk), .rst(rst), .rd_stat(rd_stat), .msi_en(msi_en), .irq(irq),
  .loop_on(loop_on), .evt(evt), .flags(flags),
  .outs_n({user2_n, user1_n, req_send_n, term_ready_n}),
  .stat_rdata(stat_rdata), .ctl_rdata(ctl_rdata)
);

// File: tb/uart_modem_ctl_bench.sv
`timescale 1ns/1ps
module uart_modem_ctl_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_ctl = 1'b0, rd_stat = 1'b0, msi_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [3:0] pins = 4'hF;   // {carrier, ring, set_ready, clr_send}, active low
  logic term_ready_n, req_send_n, user1_n, user2_n, irq;
  logic [7:0] ctl_rdata, stat_rdata;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;   // 200 MHz

  uart_modem_ctl u_uart_modem_ctl (
    .clk(clk), .rst(rst), .wr_ctl(wr_ctl), .wr_data(wr_data), .rd_stat(rd_stat),
    .msi_en(msi_en), .clr_send_n(pins[0]), .set_ready_n(pins[1]), .ring_n(pins[2]),
    .carrier_n(pins[3]), .term_ready_n(term_ready_n), .req_send_n(req_send_n),
    .user1_n(user1_n), .user2_n(user2_n), .ctl_rdata(ctl_rdata),
    .stat_rdata(stat_rdata), .irq(irq)
  );

  // behavioural reference model
  int ctl_m = 0;
  int pipe_m[$] = '{15, 15};   // [0] oldest sample = what the status sees
  int prev_m = 15;
  int flg_m = 0;

  function automatic int looped(int c);
    int v = 0;
    if (((c >> 1) & 1) == 0) v += 1;
    if ((c & 1) == 0)        v += 2;
    if (((c >> 2) & 1) == 0) v += 4;
    if (((c >> 3) & 1) == 0) v += 8;
    return v;
  endfunction

  function automatic int seen_line();
    return ((ctl_m & 16) != 0) ? looped(ctl_m) : pipe_m[0];
  endfunction

  task automatic check(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int ln = seen_line();
    int exp_outs = ((ctl_m & 16) != 0) ? 15 : ((~ctl_m) & 15);
    check("R1 status levels", stat_rdata[7:4], (~ln) & 15);
    check("R2 change flags cts/dsr/dcd", stat_rdata & 8'h0B, flg_m & 11);
    check("R3 ring flag", stat_rdata[2], (flg_m >> 2) & 1);
    check("R5 irq", irq, (msi_en && flg_m != 0) ? 1 : 0);
    check("R6/R7 handshake outputs", {user2_n, user1_n, req_send_n, term_ready_n}, exp_outs);
    check("R10 control readback", ctl_rdata, ctl_m & 31);
  endtask

  // inputs are set at a negedge; one edge is applied; compare at the next negedge
  task automatic step();
    int cur, ev;
    @(posedge clk);
    if (rst) begin
      ctl_m = 0; pipe_m = '{15, 15}; prev_m = 15; flg_m = 0;
    end else begin
      cur = seen_line();
      ev = ((prev_m ^ cur) & 11) | ((~prev_m & cur) & 4);
      flg_m = (rd_stat ? 0 : flg_m) | ev;
      prev_m = cur;
      void'(pipe_m.pop_front());
      pipe_m.push_back(int'(pins));
      if (wr_ctl) ctl_m = int'(wr_data) & 31;
    end
    @(negedge clk);
    compare_all();
    wr_ctl = 1'b0;
    rd_stat = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic write_ctl(int v);
    wr_ctl = 1'b1; wr_data = 8'(v); step();
  endtask

  task automatic read_stat();
    rd_stat = 1'b1; step();
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    idle(3);
    // R9: reset state
    check("R9 outputs after reset", {user2_n, user1_n, req_send_n, term_ready_n}, 15);
    check("R9 irq after reset", irq, 0);
    check("R9 flags after reset", stat_rdata[3:0], 0);
    rst = 1'b0;
    idle(3);
    // R6 / R10: drive each output, upper write bits ignored
    write_ctl(8'hEF);
    check("R10 upper bits read zero", ctl_rdata, 8'h0F);
    check("R6 all outputs low", {user2_n, user1_n, req_send_n, term_ready_n}, 0);
    write_ctl(8'h05);
    check("R6 terminal ready and user1 low", {user2_n, user1_n, req_send_n, term_ready_n}, 4'b1010);
    write_ctl(0);
    msi_en = 1'b1;
    // R1 / R2: clear-to-send falls; two edges to status, third sets flag
    pins[0] = 1'b0;
    step();
    check("R1 status before sync", stat_rdata[4], 0);
    step();
    check("R1 status after two edges", stat_rdata[4], 1);
    step();
    check("R2 cts flag set", stat_rdata[0], 1);
    check("R5 irq raised", irq, 1);
    idle(4);
    check("R4 flag sticky", stat_rdata[0], 1);
    read_stat();
    check("R4 flag cleared by read", stat_rdata[0], 0);
    check("R5 irq cleared by read", irq, 0);
    // R3: ring falling edge leaves flag clear, rising sets it
    pins[2] = 1'b0;
    idle(4);
    check("R3 ring fall no flag", stat_rdata[2], 0);
    pins[2] = 1'b1;
    idle(4);
    check("R3 ring rise flag", stat_rdata[2], 1);
    read_stat();
    // R4: carrier change detected on the same edge as a read is kept
    pins[3] = 1'b0;
    step(); step();
    read_stat();
    check("R4 coincident change kept", stat_rdata[3], 1);
    read_stat();
    // R5: flags with interrupt disabled
    msi_en = 1'b0;
    pins[1] = 1'b0;
    idle(4);
    check("R5 no irq when disabled", irq, 0);
    msi_en = 1'b1;
    step();
    check("R5 irq when re-enabled", irq, 1);
    read_stat();
    // R7 / R8: loopback
    write_ctl(8'h1F);
    check("R7 loopback outputs high", {user2_n, user1_n, req_send_n, term_ready_n}, 15);
    check("R8 loopback levels", stat_rdata[7:4], 4'hF);
    read_stat();
    pins = 4'h0; idle(4); pins = 4'hF; idle(4); pins = 4'h5; idle(4);
    check("R8 pins ignored in loopback", stat_rdata, 8'hF0);
    write_ctl(8'h12);
    check("R8 rts feeds cts only", stat_rdata[7:4], 4'b0001);
    write_ctl(8'h14);
    check("R8 out1 feeds ring", stat_rdata[7:4], 4'b0100);
    write_ctl(8'h10);
    check("R3 looped ring return flag", stat_rdata[2], 1);
    write_ctl(0);
    read_stat();
    // mixed traffic, model compared every cycle
    for (int i = 0; i < 2000; i++) begin
      int r = $urandom;
      if ((r & 7) == 0) pins = 4'($urandom);
      if (((r >> 3) & 15) == 0) begin wr_ctl = 1'b1; wr_data = 8'($urandom); end
      if (((r >> 7) & 7) == 0) rd_stat = 1'b1;
      if (((r >> 10) & 63) == 0) msi_en = ~msi_en;
      step();
    end
    rst = 1'b1;
    step();
    check("R9 reset mid-run outputs", {user2_n, user1_n, req_send_n, term_ready_n}, 15);
    check("R9 reset mid-run flags", stat_rdata[3:0], 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule